// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache Controller

This block is a cache that sits between a 16-bit requester and a word-wide backing memory. The requester presents a read or a write while the stall output is low. The cache then answers on a fixed schedule. It enters a lookup state one cycle after acceptance, and a hit is answered one cycle after that with a one-cycle done pulse, the hit flag and the read word.

On a miss the controller picks a victim way in the addressed set. If that line is dirty, it writes the line back as a four-word burst. It then refills the line with a four-word burst and completes the request from the fresh line. Writes use write-back with write-allocate, so a write hit never touches memory.

Tag and data storage are single-ported arrays with combinational read. They are cleared at reset, and the backing memory is reached through a request/valid port that moves one word per handshake.

Top module: `cache2w_ctrl`

## Requirements
- R1: After reset, stall, done and hit are low and every line is invalid, so the first access to any address misses.
- R2: A word address splits into a 2-bit offset in bits [1:0], a set index above it of log2(SETS) bits, and the tag in the remaining upper bits. The memory address of a line word is {tag, set, offset}.
- R3: A request accepted in the idle cycle T that hits produces done and hit together at cycle T+2, with the addressed word on the read data output for a read.
- R4: Stall is low while the controller is idle. It is high from the cycle after acceptance up to and including the cycle done is asserted.
- R5: A read miss refills the line with four memory reads at offsets 0, 1, 2, 3 in that order. It then completes with done high, hit low and the requested word from the refilled line.
- R6: Done is a one-cycle pulse. Hit is high only together with done, and only when the request caused no memory traffic.
- R7: A write hit updates only the cache and issues no memory access. A later read of that address returns the written value.
- R8: When the chosen victim is valid and dirty, its four words go to memory at offsets 0 to 3 of the old line address, with memory write enable high. This burst ends before the first refill read.
- R9: A miss fills an invalid way first, way 0 before way 1. With both ways valid it fills the least recently used way. Every hit and every fill makes the used way the most recent.
- R10: Each memory word completes in the cycle mem_valid is high while mem_req is high. Until then, mem_req, the address and the write enable stay unchanged. Read data is taken from mem_rdata in that cycle.
- R11: A write miss allocates the line through the refill. The written word is merged in the done cycle and returned by a later read, while the other words of the line keep their memory values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_addr | input | 16 | Requester word address |
| req_wdata | input | 16 | Requester write data |
| req_rd | input | 1 | Read request strobe |
| req_wr | input | 1 | Write request strobe |
| rsp_rdata | output | 16 | Read data, valid with done on a read |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_stall | output | 1 | Busy; no new request may be presented |
| rsp_hit | output | 1 | Request completed without memory traffic |
| mem_req | output | 1 | Memory word transfer request |
| mem_we | output | 1 | Memory transfer is a write |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_valid | input | 1 | Memory word transfer complete |
| mem_rdata | input | 16 | Memory read data, valid with mem_valid |

## Verification
Two functions share one cycle at the end of a write miss. The last refill word is written into the data array while the tag entry is set valid. In the very next cycle the requester's word is merged over the freshly filled line and the line is marked dirty. The bench provokes this by writing to lines that are absent, some of which also force a dirty eviction. It then reads the whole line back and expects the merged word at its offset and the memory values at the other three. A later eviction of that line must carry the merged word back to memory.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 16;
  localparam int OFF_W  = 2;
  localparam int WAYS   = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_WB,
    ST_FILL,
    ST_DONE
  } cstate_e;
endpackage

// File: rtl/cache2w_tag_ram.sv
module cache2w_tag_ram #(
  parameter int SETS  = 16,
  parameter int TAG_W = 10,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             we,
  input  logic             w_valid,
  input  logic             w_dirty,
  input  logic [TAG_W-1:0] w_tag,
  output logic             r_valid,
  output logic             r_dirty,
  output logic [TAG_W-1:0] r_tag
);
  logic             valid_q [SETS];
  logic             dirty_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) begin
        valid_q[i] <= 1'b0;
        dirty_q[i] <= 1'b0;
        tag_q[i]   <= '0;
      end
    end else if (we) begin
      valid_q[idx] <= w_valid;
      dirty_q[idx] <= w_dirty;
      tag_q[idx]   <= w_tag;
    end
  end

  assign r_valid = valid_q[idx];
  assign r_dirty = dirty_q[idx];
  assign r_tag   = tag_q[idx];
endmodule

// File: rtl/cache2w_data_ram.sv
module cache2w_data_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
  parameter int SETS = 16,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             valid0,
  input  logic             valid1,
  input  logic             touch,
  input  logic             touch_way,
  output logic             victim
);
  // Bit per set names the way to evict next.
  logic lru_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) lru_q[i] <= 1'b0;
    end else if (touch) begin
      lru_q[idx] <= ~touch_way;
    end
  end

  always_comb begin
    if (!valid0)      victim = 1'b0;
    else if (!valid1) victim = 1'b1;
    else              victim = lru_q[idx];
  end
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
  import cache2w_pkg::*;
#(
  parameter int SETS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic              req_rd,
  input  logic              req_wr,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic              rsp_stall,
  output logic              rsp_hit,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_valid,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int DA_W  = IDX_W + OFF_W;
  localparam logic [OFF_W-1:0] LAST_WORD = {OFF_W{1'b1}};

  function automatic logic [IDX_W-1:0] f_set(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [ADDR_W-1:0] f_line_word(input logic [TAG_W-1:0] t,
                                                     input logic [IDX_W-1:0] s,
                                                     input logic [OFF_W-1:0] o);
    return {t, s, o};
  endfunction

  cstate_e           state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic              is_wr_q;
  logic              way_q;
  logic              miss_q;
  logic [OFF_W-1:0]  cnt_q;
  logic [TAG_W-1:0]  vtag_q;

  logic [IDX_W-1:0]  cur_set;
  logic [TAG_W-1:0]  cur_tag;
  logic [OFF_W-1:0]  cur_off;
  assign cur_set = f_set(addr_q);
  assign cur_tag = f_tag(addr_q);
  assign cur_off = addr_q[OFF_W-1:0];

  logic              tv   [WAYS];
  logic              td   [WAYS];
  logic [TAG_W-1:0]  tt   [WAYS];
  logic [WORD_W-1:0] dr   [WAYS];
  logic [WAYS-1:0]   hit_w;

  // Named events used by the checker.
  logic accept_evt, lookup_evt, lookup_hit, word_ack, wb_last_evt, fill_last_evt;
  logic victim_way, hit_way;

  assign accept_evt    = (state_q == ST_IDLE) && (req_rd || req_wr);
  assign lookup_evt    = (state_q == ST_RD) || (state_q == ST_WR);
  assign lookup_hit    = |hit_w;
  assign hit_way       = hit_w[1];
  assign word_ack      = mem_req && mem_valid;
  assign wb_last_evt   = (state_q == ST_WB) && word_ack && (cnt_q == LAST_WORD);
  assign fill_last_evt = (state_q == ST_FILL) && word_ack && (cnt_q == LAST_WORD);

  logic [DA_W-1:0] data_addr;
  assign data_addr = {cur_set, (state_q == ST_DONE) ? cur_off : cnt_q};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic sel, t_we, d_we;
    assign sel  = (way_q == w[0]);
    assign t_we = sel && (fill_last_evt || (state_q == ST_DONE && is_wr_q));
    assign d_we = sel && (((state_q == ST_FILL) && word_ack) ||
                          ((state_q == ST_DONE) && is_wr_q));
    assign hit_w[w] = tv[w] && (tt[w] == cur_tag);

    cache2w_tag_ram #(.SETS(SETS), .TAG_W(TAG_W)) u_tag (
      .clk(clk), .rst_n(rst_n), .idx(cur_set), .we(t_we),
      .w_valid(1'b1), .w_dirty(state_q == ST_DONE), .w_tag(cur_tag),
      .r_valid(tv[w]), .r_dirty(td[w]), .r_tag(tt[w])
    );

    cache2w_data_ram #(.DEPTH(SETS << OFF_W), .W(WORD_W)) u_data (
      .clk(clk), .rst_n(rst_n), .addr(data_addr), .we(d_we),
      .wdata((state_q == ST_FILL) ? mem_rdata : wdata_q),
      .rdata(dr[w])
    );
  end

  cache2w_lru #(.SETS(SETS)) u_lru (
    .clk(clk), .rst_n(rst_n), .idx(cur_set),
    .valid0(tv[0]), .valid1(tv[1]),
    .touch(state_q == ST_DONE), .touch_way(way_q),
    .victim(victim_way)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      is_wr_q <= 1'b0;
      way_q   <= 1'b0;
      miss_q  <= 1'b0;
      cnt_q   <= '0;
      vtag_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_evt) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          is_wr_q <= req_wr;
          state_q <= req_wr ? ST_WR : ST_RD;
        end
        ST_RD, ST_WR: begin
          cnt_q <= '0;
          if (lookup_hit) begin
            way_q   <= hit_way;
            miss_q  <= 1'b0;
            state_q <= ST_DONE;
          end else begin
            way_q   <= victim_way;
            miss_q  <= 1'b1;
            vtag_q  <= tt[victim_way];
            state_q <= (tv[victim_way] && td[victim_way]) ? ST_WB : ST_FILL;
          end
        end
        ST_WB: if (word_ack) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_WORD) state_q <= ST_FILL;
        end
        ST_FILL: if (word_ack) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_WORD) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = (state_q == ST_WB) || (state_q == ST_FILL);
  assign mem_we    = (state_q == ST_WB);
  assign mem_addr  = (state_q == ST_WB) ? f_line_word(vtag_q, cur_set, cnt_q)
                                        : f_line_word(cur_tag, cur_set, cnt_q);
  assign mem_wdata = dr[way_q];

  assign rsp_done  = (state_q == ST_DONE);
  assign rsp_hit   = rsp_done && !miss_q;
  assign rsp_stall = (state_q != ST_IDLE);
  assign rsp_rdata = (rsp_done && !is_wr_q) ? dr[way_q] : '0;
endmodule

// File: rtl/cache2w_ctrl_chk.sv
module cache2w_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic accept_evt,
  input logic lookup_evt,
  input logic lookup_hit,
  input logic wb_last_evt,
  input logic rsp_done,
  input logic rsp_hit,
  input logic rsp_stall,
  input logic mem_req,
  input logic mem_we,
  input logic mem_valid,
  input logic [15:0] mem_addr
);
  p_lookup_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> lookup_evt);
  p_hit_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_evt && lookup_hit |=> rsp_done && rsp_hit && !mem_req);
  p_busy_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> rsp_stall);
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_stall |-> !mem_req && !rsp_done);
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_hit_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_done);
  p_wb_then_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_last_evt |=> mem_req && !mem_we);
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr) && $stable(mem_we));
endmodule

bind cache2w_ctrl cache2w_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .accept_evt(accept_evt), .lookup_evt(lookup_evt),
  .lookup_hit(lookup_hit), .wb_last_evt(wb_last_evt), .rsp_done(rsp_done),
  .rsp_hit(rsp_hit), .rsp_stall(rsp_stall), .mem_req(mem_req), .mem_we(mem_we),
  .mem_valid(mem_valid), .mem_addr(mem_addr)
);

// File: tb/cache2w_ctrl_tb.sv
module cache2w_ctrl_tb;
  localparam int SETS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        req_rd = 1'b0, req_wr = 1'b0;
  logic [15:0] rsp_rdata;
  logic        rsp_done, rsp_stall, rsp_hit;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic        mem_valid = 1'b0;
  logic [15:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  cache2w_ctrl #(.SETS(SETS)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_rd(req_rd), .req_wr(req_wr), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .rsp_stall(rsp_stall), .rsp_hit(rsp_hit), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  // Behavioural backing memory with configurable latency and transfer log.
  logic [15:0] bmem [4096];
  logic [15:0] arch [4096];
  int          mem_lat = 0, wait_cnt = 0;
  logic        lg_we   [16];
  logic [15:0] lg_addr [16];
  int          lg_n = 0;

  function automatic logic [15:0] init_word(input int i);
    return 16'(i * 40503) ^ 16'h5A5A;
  endfunction

  initial begin
    for (int i = 0; i < 4096; i++) begin
      bmem[i] = init_word(i);
      arch[i] = init_word(i);
    end
  end

  always @(posedge clk) begin
    mem_valid <= 1'b0;
    if (mem_req && !mem_valid) begin
      if (wait_cnt >= mem_lat) begin
        wait_cnt  <= 0;
        mem_valid <= 1'b1;
        if (mem_we) bmem[mem_addr[11:0]] <= mem_wdata;
        else        mem_rdata <= bmem[mem_addr[11:0]];
        lg_we[lg_n % 16]   <= mem_we;
        lg_addr[lg_n % 16] <= mem_addr;
        lg_n <= lg_n + 1;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  // Shadow of tag state, restated from the requirements.
  bit sv_v [SETS][2];
  bit sv_d [SETS][2];
  int sv_t [SETS][2];
  bit sv_lru [SETS];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_op(input bit wr, input int a);
    int set, tg, hw, vic, base, cyc, n_exp;
    bit exp_hit, exp_wb;
    int vt;
    logic [15:0] d;
    set = (a / 4) % SETS;
    tg  = a / (4 * SETS);
    d   = 16'(a * 7) ^ 16'hC3A1 ^ 16'(checks);
    hw  = -1;
    for (int w = 0; w < 2; w++) if (sv_v[set][w] && sv_t[set][w] == tg) hw = w;
    exp_hit = (hw >= 0);
    vic = !sv_v[set][0] ? 0 : (!sv_v[set][1] ? 1 : int'(sv_lru[set]));
    exp_wb = !exp_hit && sv_v[set][vic] && sv_d[set][vic];
    vt = sv_t[set][vic];
    while (rsp_stall) @(negedge clk);
    base = lg_n;
    req_addr = 16'(a); req_wdata = d; req_rd = !wr; req_wr = wr;
    @(negedge clk);
    req_rd = 1'b0; req_wr = 1'b0;
    cyc = 1;
    chk(rsp_stall == 1'b1, "R4 stall after accept", rsp_stall, 1);
    while (!rsp_done && cyc < 2000) begin @(negedge clk); cyc++; end
    chk(rsp_done == 1'b1, "R6 done seen", rsp_done, 1);
    chk(rsp_stall == 1'b1, "R4 stall in done cycle", rsp_stall, 1);
    chk(rsp_hit == exp_hit, exp_hit ? "R3 hit flag" : "R9 R1 miss flag", rsp_hit, exp_hit);
    if (exp_hit) chk(cyc == 2, "R3 two-cycle hit", cyc, 2);
    if (!wr) chk(rsp_rdata == arch[a], wr ? "R11" : "R5 R7 R11 read data", rsp_rdata, arch[a]);
    n_exp = exp_hit ? 0 : (exp_wb ? 8 : 4);
    chk(lg_n - base == n_exp, exp_hit ? "R7 R6 no memory traffic" : "R5 R8 burst length",
        lg_n - base, n_exp);
    if (lg_n - base == n_exp) begin
      for (int k = 0; k < n_exp; k++) begin
        int ea;
        bit ew;
        ew = exp_wb && k < 4;
        ea = ((ew ? vt : tg) * SETS + set) * 4 + (k % 4);
        chk(lg_we[(base + k) % 16] == ew, "R8 burst direction order", lg_we[(base + k) % 16], ew);
        chk(lg_addr[(base + k) % 16] == 16'(ea), "R2 R5 R8 burst address",
            lg_addr[(base + k) % 16], ea);
        if (ew) chk(bmem[ea] == arch[ea], "R8 written-back word", bmem[ea], arch[ea]);
      end
    end
    if (wr) arch[a] = d;
    if (!exp_hit) begin
      hw = vic; sv_v[set][hw] = 1; sv_d[set][hw] = 0; sv_t[set][hw] = tg;
    end
    if (wr) sv_d[set][hw] = 1;
    sv_lru[set] = (hw == 0);
    @(negedge clk);
    chk(rsp_done == 1'b0, "R6 done one cycle", rsp_done, 0);
    chk(rsp_stall == 1'b0, "R4 stall low when idle", rsp_stall, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      sv_lru[s] = 0;
      for (int w = 0; w < 2; w++) begin sv_v[s][w] = 0; sv_d[s][w] = 0; sv_t[s][w] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_stall == 0, "R1 reset stall", rsp_stall, 0);
    chk(rsp_done == 0, "R1 reset done", rsp_done, 0);
    chk(rsp_hit == 0, "R1 reset hit", rsp_hit, 0);
    chk(mem_req == 0, "R1 reset memory idle", mem_req, 0);

    // R5/R2: sweep of 8 lines, fits both ways of every set.
    mem_lat = 0;
    for (int a = 0; a < 32; a++) do_op(0, a);
    // R7: write hits.
    mem_lat = 1;
    for (int a = 0; a < 32; a += 3) do_op(1, a);
    for (int a = 0; a < 32; a++) do_op(0, a);
    // R8/R9: conflicting lines evict dirty victims.
    mem_lat = 3;
    for (int a = 32; a < 64; a++) do_op(0, a);
    // R9: set 0 recency: touch tag 2, then bring tag 4 in, evicting tag 3.
    do_op(0, 32);
    do_op(0, 64);
    do_op(0, 48);
    // R11: write misses, some forcing dirty evictions.
    mem_lat = 2;
    for (int a = 0; a < 16; a += 5) do_op(1, 96 + a);
    for (int a = 0; a < 16; a++) do_op(1, 1 + a * 17);
    // Read back everything touched, under several latencies.
    for (int a = 0; a < 320; a++) begin
      mem_lat = a % 4;
      do_op(0, a);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule